// File: doc/BRIEF.md
# Typed Interrupt Pending Register

This block keeps one pending flag for each interrupt line of a core. Two agents change the flags. The core writes through a set port and a clear port, each a single-cycle strobe with a data vector. The external interrupt lines drive the flags through a synchronizer.

Every line has a fixed kind, chosen by four disjoint mask parameters: software, edge-triggered, level-sensitive or non-maskable. The kind of a line decides which agent may change its flag. Lines that appear in no mask never become pending.

The pending vector feeds the enable and priority logic downstream, and the same vector is what software reads back. All updates to a flag in one cycle are merged into a single next-state equation. A core write and a hardware event in the same cycle therefore both take effect.

Top module: `irq_pend_reg`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, pend_o is all zeros.
- R2: A set strobe raises only the flags of software lines, in the cycle after the strobe. It never lowers any flag, and it has no effect on lines of any other kind.
- R3: A clear strobe lowers the flags of software and edge lines whose data bit is 1. Level, non-maskable and unassigned flags are left unchanged.
- R4: An edge line's flag rises three clock edges after irq_i goes high: two synchronizer stages and then the latch. The flag stays set after the line falls, until it is cleared.
- R5: A level line's flag equals its input delayed by three clock edges. Set, clear and acknowledge strobes have no effect on it.
- R6: A non-maskable flag latches on a rising edge of its line. The clear port cannot lower it. An acknowledge bit of 1 on nmi_ack_i lowers it in the next cycle.
- R7: When set and clear hit the same software bit in the same cycle, the flag ends up set.
- R8: When an edge arrives in the same cycle as a clear of that bit, the flag stays set. Hardware events and core writes to different bits in the same cycle all take effect.
- R9: Lines outside all four masks always read 0 on pend_o.
- R10: nmi_ack_i bits of lines that are not non-maskable have no effect.

With the default parameters, the line kinds are:
- software: bits 3:0
- edge: bits 7:4
- level: bits 11:8
- non-maskable: bits 13:12
- unassigned: bits 15:14

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_IRQ | Raw external interrupt lines |
| set_we_i | input | 1 | Set-port write strobe |
| set_data_i | input | N_IRQ | Bits to set |
| clr_we_i | input | 1 | Clear-port write strobe |
| clr_data_i | input | N_IRQ | Bits to clear |
| nmi_ack_i | input | N_IRQ | Acknowledge of non-maskable lines, one bit per line |
| pend_o | output | N_IRQ | Pending vector |

## Verification
The hardest case to produce is a clear strobe that lands in exactly the cycle in which a synchronized rising edge reaches the latch of a flag that is already pending. The stimulus first lets the line fall and settle. It then raises the line and issues the clear two cycles later, so that the edge and the clear coincide at the third clock edge. A set strobe to a software bit is issued in the same cycle, to show that writes and hardware events to different bits merge.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_SW,
    KIND_EDGE,
    KIND_LEVEL,
    KIND_NMI
  } irq_kind_e;

  function automatic irq_kind_e kind_of(input logic sw, input logic edg,
                                        input logic lvl, input logic nmi);
    if (sw)       return KIND_SW;
    else if (edg) return KIND_EDGE;
    else if (lvl) return KIND_LEVEL;
    else if (nmi) return KIND_NMI;
    return KIND_NONE;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core
  import irq_pend_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] SW_MASK    = '0,
  parameter logic [WIDTH-1:0] EDGE_MASK  = '0,
  parameter logic [WIDTH-1:0] LEVEL_MASK = '0,
  parameter logic [WIDTH-1:0] NMI_MASK   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic [WIDTH-1:0] ack_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] pend_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    localparam irq_kind_e KIND =
      kind_of(SW_MASK[i], EDGE_MASK[i], LEVEL_MASK[i], NMI_MASK[i]);
    logic nxt;

    // set/raise terms are OR-ed after the drop term so they win
    always_comb begin
      unique case (KIND)
        KIND_SW:    nxt = (pend_q[i] & ~clr_i[i]) | set_i[i];
        KIND_EDGE:  nxt = (pend_q[i] & ~clr_i[i]) | rise_i[i];
        KIND_LEVEL: nxt = sync_i[i];
        KIND_NMI:   nxt = (pend_q[i] & ~ack_i[i]) | rise_i[i];
        default:    nxt = 1'b0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= nxt;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned N_IRQ       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [N_IRQ-1:0] SW_MASK    = 16'h000F,
  parameter logic [N_IRQ-1:0] EDGE_MASK  = 16'h00F0,
  parameter logic [N_IRQ-1:0] LEVEL_MASK = 16'h0F00,
  parameter logic [N_IRQ-1:0] NMI_MASK   = 16'h3000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             set_we_i,
  input  logic [N_IRQ-1:0] set_data_i,
  input  logic             clr_we_i,
  input  logic [N_IRQ-1:0] clr_data_i,
  input  logic [N_IRQ-1:0] nmi_ack_i,
  output logic [N_IRQ-1:0] pend_o
);
  localparam logic [N_IRQ-1:0] SET_OK = SW_MASK;
  localparam logic [N_IRQ-1:0] CLR_OK = SW_MASK | EDGE_MASK;
  localparam logic [N_IRQ-1:0] ACK_OK = NMI_MASK;

  logic [N_IRQ-1:0] line_sync, line_rise;
  logic [N_IRQ-1:0] set_eff, clr_eff, ack_eff;

  irq_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(irq_i), .sync_o(line_sync)
  );

  irq_edge_det #(.WIDTH(N_IRQ)) u_edge (
    .clk_i, .rst_ni, .level_i(line_sync), .rise_o(line_rise)
  );

  assign set_eff = {N_IRQ{set_we_i}} & set_data_i & SET_OK;
  assign clr_eff = {N_IRQ{clr_we_i}} & clr_data_i & CLR_OK;
  assign ack_eff = nmi_ack_i & ACK_OK;

  irq_pend_core #(
    .WIDTH(N_IRQ), .SW_MASK(SW_MASK), .EDGE_MASK(EDGE_MASK),
    .LEVEL_MASK(LEVEL_MASK), .NMI_MASK(NMI_MASK)
  ) u_core (
    .clk_i, .rst_ni,
    .sync_i(line_sync), .rise_i(line_rise),
    .set_i(set_eff), .clr_i(clr_eff), .ack_i(ack_eff),
    .pend_o(pend_o)
  );
endmodule

// File: rtl/irq_pend_reg_chk.sv
module irq_pend_reg_chk #(
  parameter int unsigned N_IRQ = 16,
  parameter logic [N_IRQ-1:0] SW_MASK    = '0,
  parameter logic [N_IRQ-1:0] EDGE_MASK  = '0,
  parameter logic [N_IRQ-1:0] LEVEL_MASK = '0,
  parameter logic [N_IRQ-1:0] NMI_MASK   = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             set_we_i,
  input logic [N_IRQ-1:0] set_data_i,
  input logic             clr_we_i,
  input logic [N_IRQ-1:0] clr_data_i,
  input logic [N_IRQ-1:0] nmi_ack_i,
  input logic [N_IRQ-1:0] sync_i,
  input logic [N_IRQ-1:0] pend_o
);
  localparam logic [N_IRQ-1:0] ANY = SW_MASK | EDGE_MASK | LEVEL_MASK | NMI_MASK;
  localparam logic [N_IRQ-1:0] ZERO = '0;

  p_unassigned_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~ANY) == ZERO);

  p_set_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((pend_o & $past(set_data_i & SW_MASK)) == $past(set_data_i & SW_MASK)));

  p_sw_rise_needs_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~$past(pend_o) & SW_MASK & ~$past(set_we_i ? set_data_i : ZERO)) == ZERO);

  p_edge_fall_needs_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_o) & ~pend_o & EDGE_MASK & ~$past(clr_we_i ? clr_data_i : ZERO)) == ZERO);

  p_nmi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_o) & ~pend_o & NMI_MASK & ~$past(nmi_ack_i)) == ZERO);

  p_level_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & LEVEL_MASK) == ($past(sync_i) & LEVEL_MASK));
endmodule

bind irq_pend_reg irq_pend_reg_chk #(
  .N_IRQ(N_IRQ), .SW_MASK(SW_MASK), .EDGE_MASK(EDGE_MASK),
  .LEVEL_MASK(LEVEL_MASK), .NMI_MASK(NMI_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_we_i(set_we_i), .set_data_i(set_data_i),
  .clr_we_i(clr_we_i), .clr_data_i(clr_data_i), .nmi_ack_i(nmi_ack_i),
  .sync_i(line_sync), .pend_o(pend_o)
);

// File: tb/sim_irq_pend_reg.sv
`timescale 1ns/1ps
module sim_irq_pend_reg;
  localparam int N = 16;
  localparam logic [N-1:0] M_SW  = 16'h000F;
  localparam logic [N-1:0] M_EDG = 16'h00F0;
  localparam logic [N-1:0] M_LVL = 16'h0F00;
  localparam logic [N-1:0] M_NMI = 16'h3000;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq = '0, sd = '0, cd = '0, ack = '0;
  logic swe = 0, cwe = 0;
  logic [N-1:0] pend;

  always #5 clk = ~clk;

  irq_pend_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .set_we_i(swe), .set_data_i(sd),
    .clr_we_i(cwe), .clr_data_i(cd), .nmi_ack_i(ack), .pend_o(pend)
  );

  typedef struct { logic [N-1:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;

  // bench model state: flags and the three most recent driven line values
  logic [N-1:0] m_pend = '0, h1 = '0, h2 = '0, h3 = '0;

  task automatic step(input logic [N-1:0] l, input logic we_s, input logic [N-1:0] ds,
                      input logic we_c, input logic [N-1:0] dc,
                      input logic [N-1:0] a, input string tag);
    logic [N-1:0] seen, rise, up, down;
    item_t it;
    @(negedge clk);
    irq = l; swe = we_s; sd = ds; cwe = we_c; cd = dc; ack = a;
    seen = h2; rise = h2 & ~h3;   // line value that has crossed the synchronizer
    up   = (we_s ? ds & M_SW : '0) | (rise & (M_EDG | M_NMI));
    down = (we_c ? dc & (M_SW | M_EDG) : '0) | (a & M_NMI);
    m_pend = (((m_pend & ~down) | up) & (M_SW | M_EDG | M_NMI)) | (seen & M_LVL);
    h3 = h2; h2 = h1; h1 = l;
    it.exp = m_pend; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input logic [N-1:0] l, input string tag);
    step(l, 0, '0, 0, '0, '0, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (pend !== it.exp) begin
          fails++;
          $display("FAIL %s pend=%h exp=%h", it.tag, pend, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : driver
    irq = 16'hFFFF; swe = 1; sd = '1; cwe = 0;
    repeat (3) @(posedge clk);
    #2; checks++;
    if (pend !== '0) begin fails++; $display("FAIL R1 pend=%h exp=0000", pend); end
    @(negedge clk); irq = '0; swe = 0; sd = '0; rst_n = 1;
    idle('0, "R1"); idle('0, "R1"); idle('0, "R1");
    // set port: software only, never clears
    step('0, 1, 16'hFFFF, 0, '0, '0, "R2");
    step('0, 1, 16'h0000, 0, '0, '0, "R2");
    step('0, 0, '0, 1, 16'h0001, '0, "R3");
    // edge lines latch, hold after fall
    idle(16'h00F0, "R4"); idle(16'h00F0, "R4"); idle(16'h00F0, "R4"); idle(16'h00F0, "R4");
    idle('0, "R4"); idle('0, "R4"); idle('0, "R4");
    step('0, 0, '0, 1, 16'hFFFF, '0, "R3");
    // level lines follow input, ignore writes
    idle(16'h0F00, "R5"); idle(16'h0F00, "R5"); idle(16'h0F00, "R5");
    step(16'h0F00, 1, 16'hFFFF, 0, '0, '0, "R5");
    step(16'h0F00, 0, '0, 1, 16'hFFFF, '0, "R5");
    step(16'h0500, 0, '0, 0, '0, 16'hFFFF, "R5");
    idle('0, "R5"); idle('0, "R5"); idle('0, "R5");
    // non-maskable: latch, resist clear, drop on ack
    idle(16'h1010, "R6"); idle(16'h1010, "R6"); idle(16'h1010, "R6");
    step('0, 0, '0, 1, 16'hFFFF, '0, "R6");
    step('0, 0, '0, 0, '0, 16'h0FFF, "R10");
    idle('0, "R10");
    step('0, 0, '0, 0, '0, 16'h1000, "R6");
    idle('0, "R6");
    // set and clear same bit
    step('0, 1, 16'h0002, 1, 16'h0002, '0, "R7");
    step('0, 1, 16'h0004, 1, 16'h0006, '0, "R7");
    // edge coinciding with clear; set to a different bit merges
    idle(16'h0010, "R8"); idle(16'h0010, "R8"); idle(16'h0010, "R8");
    idle('0, "R8"); idle('0, "R8"); idle('0, "R8");
    idle(16'h0010, "R8"); idle(16'h0010, "R8");
    step(16'h0010, 1, 16'h0001, 1, 16'h0010, '0, "R8");
    idle(16'h0010, "R8");
    // unassigned lines
    step(16'hC000, 1, 16'hC000, 0, '0, 16'hC000, "R9");
    idle(16'hC000, "R9"); idle(16'hC000, "R9"); idle(16'hC000, "R9");
    step('0, 0, '0, 1, 16'hFFFF, 16'hFFFF, "R9");
    idle('0, "R9"); idle('0, "R9");
    wait (q.size() == 0);
    @(posedge clk); #3;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule